// File: doc/BRIEF.md
# Page-Program Block-Erase Storage Engine

This block is a synthesizable model of a NAND-style storage array. Data moves between the host and the array only in whole pages, through a single page buffer. The host fills the buffer one byte at a time and then commits it to a chosen page. A page read copies one stored page into the buffer so the host can stream it out. An erase returns every page of one block to the all-ones state.

Programming can only clear bits. The stored page becomes the bitwise AND of its old contents and the buffer, so a one in the buffer leaves the stored bit as it was. Only an erase of the whole block can bring bits back to one. Each array operation holds a busy flag for its own parameterized number of cycles. An operation request that arrives while the engine is busy is dropped and sets a sticky error flag.

Top module: `flash_page_engine`

## Requirements
- R1: After reset, every byte of the array and of the page buffer is 0xFF, the column pointer is 0, and `busy` and `err_busy` are both 0.
- R2: A `load_start` pulse sets every buffer byte to 0xFF and moves the column pointer to `load_col`. Each `wr_en` cycle stores `wr_data` at the column pointer and then advances the pointer. After the last byte (PAGE_BYTES-1) the pointer wraps to 0.
- R3: A program request (`op_code` 2'b10) replaces the addressed page with old AND buffer. Buffer bytes that were never written therefore leave the stored bytes unchanged. When the program completes, the buffer returns to all 0xFF.
- R4: Programming cannot set a bit. A buffer holding all ones leaves the stored page as it was, and a bit that is already zero stays zero.
- R5: An erase request (`op_code` 2'b11) sets every page of the block that contains `op_page` to 0xFF. The block index is op_page / PAGES_PER_BLK. Pages in other blocks keep their contents.
- R6: A read request (`op_code` 2'b01) copies the addressed page into the buffer and sets the column pointer to 0. Each `rd_en` cycle then advances the pointer, and `rd_data` always shows the buffer byte at the pointer.
- R7: A `col_set` pulse moves the column pointer to `col_addr` and leaves the buffer contents unchanged.
- R8: When a request is accepted, `busy` goes high on the next cycle. It stays high for T_READ, T_PROG or T_ERASE cycles (read, program, erase), and the result is visible in the same cycle that `busy` falls. A request with `op_code` 2'b00 does nothing and does not raise `busy`.
- R9: A request with a nonzero code that arrives while `busy` is high has no effect on the array. It sets `err_busy`, which then stays 1 until reset.
- R10: While `busy` is high, `load_start`, `wr_en`, `col_set` and `rd_en` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_start | input | 1 | Clear the buffer to 0xFF and set the load column |
| load_col | input | COL_W | Starting column for buffer load |
| wr_en | input | 1 | Write one byte into the buffer |
| wr_data | input | 8 | Byte to write |
| col_set | input | 1 | Move the column pointer |
| col_addr | input | COL_W | New column pointer value |
| rd_en | input | 1 | Advance the read column pointer |
| rd_data | output | 8 | Buffer byte at the column pointer |
| op_req | input | 1 | Array operation request |
| op_code | input | 2 | 00 none, 01 read, 10 program, 11 erase |
| op_page | input | PA_W | Page address (block * PAGES_PER_BLK + page) |
| busy | output | 1 | Array operation in progress |
| err_busy | output | 1 | Sticky flag: a request arrived while busy |

## Verification
A request that is accepted at a clock edge raises `busy` right after that edge. The array or buffer result lands at the edge that lowers `busy`, which is T cycles after the accept. The bench drives inputs on falling edges and samples there. It counts the falling edges on which `busy` reads high, expects that count to equal T, and only then streams the buffer. Buffer loads and reads take effect one edge after the control strobe, so each streamed byte is compared at the falling edge before the pointer advances.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  // block index of a page address
  function automatic int unsigned blk_of(int unsigned pa, int unsigned ppb);
    return pa / ppb;
  endfunction

  // next column with wrap at the page end
  function automatic int unsigned col_next(int unsigned col, int unsigned nbytes);
    return (col == nbytes - 1) ? 0 : col + 1;
  endfunction

  // program can only clear bits
  function automatic logic [7:0] prog_merge(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/fpe_seq.sv
module fpe_seq
  import fpe_pkg::*;
#(
  parameter int unsigned PA_W    = 7,
  parameter int unsigned T_READ  = 4,
  parameter int unsigned T_PROG  = 10,
  parameter int unsigned T_ERASE = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_req,
  input  logic [1:0]      op_code,
  input  logic [PA_W-1:0] op_page,
  output logic            busy,
  output logic            err_busy,
  output logic            op_accept,
  output logic            op_reject,
  output logic            op_done,
  output op_e             cur_code,
  output logic [PA_W-1:0] cur_page
);
  localparam int unsigned CNT_W = $clog2(T_ERASE + 1);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] dur_of(op_e c);
    case (c)
      OP_READ: return CNT_W'(T_READ);
      OP_PROG: return CNT_W'(T_PROG);
      default: return CNT_W'(T_ERASE);
    endcase
  endfunction

  assign op_accept = op_req && !busy && (op_code != 2'b00);
  assign op_reject = op_req && busy && (op_code != 2'b00);
  assign op_done   = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_busy <= 1'b0;
      cnt_q    <= '0;
      cur_code <= OP_NONE;
      cur_page <= '0;
    end else begin
      if (op_accept) begin
        busy     <= 1'b1;
        cnt_q    <= dur_of(op_e'(op_code)) - CNT_W'(1);
        cur_code <= op_e'(op_code);
        cur_page <= op_page;
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - CNT_W'(1);
      end
      if (op_reject) err_busy <= 1'b1;
    end
  end
endmodule

// File: rtl/fpe_array.sv
module fpe_array
  import fpe_pkg::*;
#(
  parameter int unsigned PAGE_BYTES    = 16,
  parameter int unsigned PAGES_PER_BLK = 32,
  parameter int unsigned NUM_BLKS      = 4,
  localparam int unsigned NUM_PAGES    = PAGES_PER_BLK * NUM_BLKS,
  localparam int unsigned PA_W         = $clog2(NUM_PAGES),
  localparam int unsigned PAGE_W       = PAGE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  op_e               cur_code,
  input  logic [PA_W-1:0]   cur_page,
  input  logic [PAGE_W-1:0] buf_page,
  output logic [PAGE_W-1:0] rd_page
);
  logic [PAGE_W-1:0] mem [NUM_PAGES];
  logic [PAGE_W-1:0] merged;

  assign rd_page = mem[cur_page];

  always_comb begin
    for (int b = 0; b < PAGE_BYTES; b++)
      merged[8*b +: 8] = prog_merge(mem[cur_page][8*b +: 8], buf_page[8*b +: 8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++) mem[p] <= '1;
    end else if (op_done) begin
      if (cur_code == OP_PROG) begin
        mem[cur_page] <= merged;
      end else if (cur_code == OP_ERASE) begin
        for (int p = 0; p < NUM_PAGES; p++)
          if (blk_of(p, PAGES_PER_BLK) == blk_of(int'(cur_page), PAGES_PER_BLK))
            mem[p] <= '1;
      end
    end
  end
endmodule

// File: rtl/fpe_pagebuf.sv
module fpe_pagebuf
  import fpe_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned COL_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = PAGE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              load_start,
  input  logic [COL_W-1:0]  load_col,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              col_set,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              rd_en,
  input  logic              fill_en,
  input  logic [PAGE_W-1:0] fill_page,
  input  logic              reset_ones,
  output logic [7:0]        rd_data,
  output logic [PAGE_W-1:0] page_q
);
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_inc;

  assign col_inc = COL_W'(col_next(int'(col_q), PAGE_BYTES));
  assign rd_data = page_q[8*int'(col_q) +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '1;
      col_q  <= '0;
    end else if (fill_en) begin
      page_q <= fill_page;
      col_q  <= '0;
    end else if (reset_ones) begin
      page_q <= '1;
    end else if (!busy) begin
      if (load_start) begin
        page_q <= '1;
        col_q  <= load_col;
      end else if (wr_en) begin
        page_q[8*int'(col_q) +: 8] <= wr_data;
        col_q <= col_inc;
      end else if (col_set) begin
        col_q <= col_addr;
      end else if (rd_en) begin
        col_q <= col_inc;
      end
    end
  end
endmodule

// File: rtl/flash_page_engine.sv
module flash_page_engine
  import fpe_pkg::*;
#(
  parameter int unsigned PAGE_BYTES    = 16,
  parameter int unsigned PAGES_PER_BLK = 32,
  parameter int unsigned NUM_BLKS      = 4,
  parameter int unsigned T_READ        = 4,
  parameter int unsigned T_PROG        = 10,
  parameter int unsigned T_ERASE       = 24,
  localparam int unsigned NUM_PAGES    = PAGES_PER_BLK * NUM_BLKS,
  localparam int unsigned PA_W         = $clog2(NUM_PAGES),
  localparam int unsigned COL_W        = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W       = PAGE_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [COL_W-1:0] load_col,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             col_set,
  input  logic [COL_W-1:0] col_addr,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             op_req,
  input  logic [1:0]       op_code,
  input  logic [PA_W-1:0]  op_page,
  output logic             busy,
  output logic             err_busy
);
  // internal events, brought out for the checker
  logic              op_accept;
  logic              op_reject;
  logic              op_done;
  logic              read_done;
  logic              prog_done;
  op_e               cur_code;
  logic [PA_W-1:0]   cur_page;
  logic [PAGE_W-1:0] buf_page;
  logic [PAGE_W-1:0] arr_page;

  assign read_done = op_done && (cur_code == OP_READ);
  assign prog_done = op_done && (cur_code == OP_PROG);

  fpe_seq #(
    .PA_W(PA_W), .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_code(op_code),
    .op_page(op_page), .busy(busy), .err_busy(err_busy),
    .op_accept(op_accept), .op_reject(op_reject), .op_done(op_done),
    .cur_code(cur_code), .cur_page(cur_page)
  );

  fpe_array #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLK(PAGES_PER_BLK), .NUM_BLKS(NUM_BLKS)
  ) array_i (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .cur_code(cur_code),
    .cur_page(cur_page), .buf_page(buf_page), .rd_page(arr_page)
  );

  fpe_pagebuf #(
    .PAGE_BYTES(PAGE_BYTES)
  ) buf_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .load_start(load_start),
    .load_col(load_col), .wr_en(wr_en), .wr_data(wr_data),
    .col_set(col_set), .col_addr(col_addr), .rd_en(rd_en),
    .fill_en(read_done), .fill_page(arr_page), .reset_ones(prog_done),
    .rd_data(rd_data), .page_q(buf_page)
  );
endmodule

// File: rtl/fpe_chk.sv
module fpe_chk #(
  parameter int unsigned T_READ  = 4,
  parameter int unsigned T_PROG  = 10,
  parameter int unsigned T_ERASE = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       op_accept,
  input logic       op_reject,
  input logic       op_done,
  input logic [1:0] op_code,
  input logic       busy,
  input logic       err_busy
);
  int unsigned busy_len;
  int unsigned exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= 0;
      exp_len  <= 0;
    end else if (op_accept) begin
      busy_len <= 0;
      exp_len  <= (op_code == 2'b01) ? T_READ : (op_code == 2'b10) ? T_PROG : T_ERASE;
    end else if (busy) begin
      busy_len <= busy_len + 1;
    end
  end

  a_r8_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> busy);
  a_r8_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy);
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == exp_len));
  a_r9_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_accept);
  a_r9_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |=> err_busy);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |=> err_busy);
endmodule

bind flash_page_engine fpe_chk #(
  .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .op_accept(op_accept), .op_reject(op_reject),
  .op_done(op_done), .op_code(op_code), .busy(busy), .err_busy(err_busy)
);

// File: tb/flash_page_engine_tb_top.sv
module flash_page_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PB  = 16;
  localparam int PPB = 32;
  localparam int NB  = 4;
  localparam int TR  = 4;
  localparam int TP  = 10;
  localparam int TE  = 24;
  localparam int NP  = PPB * NB;
  localparam int PA_W  = $clog2(NP);
  localparam int COL_W = $clog2(PB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_start = 0, wr_en = 0, col_set = 0, rd_en = 0, op_req = 0;
  logic [COL_W-1:0] load_col = '0, col_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] op_code = '0;
  logic [PA_W-1:0] op_page = '0;
  logic [7:0] rd_data;
  logic busy, err_busy;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] ref_mem [NP][PB];
  logic [7:0] ref_buf [PB];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_engine #(
    .PAGE_BYTES(PB), .PAGES_PER_BLK(PPB), .NUM_BLKS(NB),
    .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_col(load_col),
    .wr_en(wr_en), .wr_data(wr_data), .col_set(col_set), .col_addr(col_addr),
    .rd_en(rd_en), .rd_data(rd_data), .op_req(op_req), .op_code(op_code),
    .op_page(op_page), .busy(busy), .err_busy(err_busy)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 37 + k * 11) ^ (k << 3));
  endfunction

  task automatic load_bytes(int col, int n, int seed, bit use_const, logic [7:0] cval);
    @(negedge clk);
    load_start = 1; load_col = COL_W'(col);
    @(negedge clk);
    load_start = 0; wr_en = 1;
    for (int i = 0; i < PB; i++) ref_buf[i] = 8'hFF;
    for (int k = 0; k < n; k++) begin
      wr_data = use_const ? cval : pat(seed, k);
      ref_buf[(col + k) % PB] = wr_data;
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic stream_check(string req);
    @(negedge clk);
    col_set = 1; col_addr = '0;
    @(negedge clk);
    col_set = 0; rd_en = 1;
    for (int i = 0; i < PB; i++) begin
      check(rd_data === ref_buf[i], req, rd_data, ref_buf[i]);
      @(negedge clk);
    end
    rd_en = 0;
  endtask

  task automatic do_op(logic [1:0] code, int page);
    int n;
    int exp_n;
    @(negedge clk);
    op_req = 1; op_code = code; op_page = PA_W'(page);
    @(negedge clk);
    op_req = 0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    exp_n = (code == 2'b01) ? TR : (code == 2'b10) ? TP : (code == 2'b11) ? TE : 0;
    check(n == exp_n, "R8 busy length", n, exp_n);
    case (code)
      2'b01: for (int i = 0; i < PB; i++) ref_buf[i] = ref_mem[page][i];
      2'b10: for (int i = 0; i < PB; i++) begin
               ref_mem[page][i] = ref_mem[page][i] & ref_buf[i];
               ref_buf[i] = 8'hFF;
             end
      2'b11: for (int p = 0; p < NP; p++)
               if (p / PPB == page / PPB)
                 for (int i = 0; i < PB; i++) ref_mem[p][i] = 8'hFF;
      default: ;
    endcase
  endtask

  task automatic read_check(int page, string req);
    do_op(2'b01, page);
    check(rd_data === ref_buf[0], req, rd_data, ref_buf[0]);
    stream_check(req);
  endtask

  task automatic t_reset;
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(err_busy === 1'b0, "R1 err", err_busy, 0);
    check(rd_data === 8'hFF, "R1 buffer col0", rd_data, 8'hFF);
    stream_check("R1 buffer");
    read_check(0, "R1 page0");
    read_check(NP - 1, "R1 last page");
  endtask

  task automatic t_load;
    load_bytes(3, 2, 5, 0, 8'h00);
    stream_check("R2 partial load");
    load_bytes(PB - 1, 3, 9, 0, 8'h00);
    stream_check("R2 wrap");
  endtask

  task automatic t_colset;
    load_bytes(0, PB, 2, 0, 8'h00);
    @(negedge clk);
    col_set = 1; col_addr = COL_W'(7);
    @(negedge clk);
    col_set = 0;
    check(rd_data === ref_buf[7], "R7 col_set", rd_data, ref_buf[7]);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check(rd_data === ref_buf[8], "R6 rd_en advance", rd_data, ref_buf[8]);
    stream_check("R7 buffer unchanged");
  endtask

  task automatic t_program;
    load_bytes(0, PB, 21, 0, 8'h00);
    do_op(2'b10, 5);
    stream_check("R3 buffer back to ones");
    read_check(5, "R3 full program");
    load_bytes(2, 3, 33, 0, 8'h00);
    do_op(2'b10, 5);
    read_check(5, "R3 AND merge");
    load_bytes(0, PB, 0, 1, 8'hFF);
    do_op(2'b10, 5);
    read_check(5, "R4 ones keep page");
    load_bytes(0, PB, 44, 0, 8'h00);
    do_op(2'b10, 40);
    read_check(40, "R6 read other block");
  endtask

  task automatic t_erase;
    do_op(2'b11, 7);
    read_check(5, "R5 erased page");
    read_check(40, "R5 other block kept");
  endtask

  task automatic t_noop;
    do_op(2'b00, 3);
    check(err_busy === 1'b0, "R8 noop no error", err_busy, 0);
  endtask

  task automatic t_busy;
    load_bytes(0, PB, 0, 1, 8'h00);
    @(negedge clk);
    op_req = 1; op_code = 2'b11; op_page = PA_W'(3);
    @(negedge clk);
    op_req = 0;
    check(busy === 1'b1, "R8 busy after accept", busy, 1);
    wr_en = 1; wr_data = 8'h5A;
    op_req = 1; op_code = 2'b10; op_page = PA_W'(50);
    @(negedge clk);
    wr_en = 0; op_req = 0;
    check(err_busy === 1'b1, "R9 err set", err_busy, 1);
    load_start = 1; load_col = COL_W'(4);
    @(negedge clk);
    load_start = 0;
    while (busy) @(negedge clk);
    for (int p = 0; p < PPB; p++)
      for (int i = 0; i < PB; i++) ref_mem[p][i] = 8'hFF;
    stream_check("R10 buffer ignored while busy");
    read_check(50, "R9 rejected program no effect");
    read_check(5, "R5 erase ran");
    check(err_busy === 1'b1, "R9 err sticky", err_busy, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion (all R)");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PB; i++) ref_mem[p][i] = 8'hFF;
    for (int i = 0; i < PB; i++) ref_buf[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_colset();
    t_program();
    t_erase();
    t_noop();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule